// File: doc/BRIEF.md
# PS/2 Mouse Movement Report Receiver

This block listens to the device-to-host traffic of a PS/2 pointing device. The clock and data lines are open-drain and rest high. Both lines are first brought into the system clock domain. Each falling edge of the device clock then samples one bit, and the block checks the framing of every 11-bit word. Three good words in a row are combined into one movement report. The report gives the two button states, the horizontal and vertical motion as 9-bit two's-complement numbers, and the two overflow flags. A single-cycle strobe marks each new report.

Bad words and bytes out of place are thrown away so that the block can find the packet boundary again. If the device clock goes quiet for a programmable number of system cycles partway through a word or a packet, the block also drops back to the start.

Top module: `ps2_mouse_rx`

## Requirements
- R1: Reset is synchronous and active high. After reset, `rpt_vld`, both button outputs, both overflow flags and both movement values are all 0.
- R2: A word is valid only in this form: a 0 start bit, then eight data bits with the least significant first, then a parity bit that makes the nine data and parity bits hold an odd number of ones, then a 1 stop bit. A word with the wrong parity or a 0 stop bit yields no byte.
- R3: Bits are sampled on falling edges of the device clock after a two-stage synchroniser. `rpt_vld` goes high exactly 4 system clock cycles after the device clock pin falls for the stop bit of the third byte.
- R4: Three accepted bytes form one report, in the order status, horizontal, vertical. `rpt_vld` is high for exactly one cycle per report.
- R5: Status bit 0 drives `btn_left` and bit 1 drives `btn_right`. Bit 4 is the horizontal sign and bit 5 the vertical sign. Bit 6 drives `ovf_x` and bit 7 drives `ovf_y`. `move_x` = {status bit 4, horizontal byte} and `move_y` = {status bit 5, vertical byte}.
- R6: A start bit of 1, a bad stop bit or a bad parity drops any partly gathered packet. The next accepted byte is then taken as a status byte.
- R7: A byte offered as status whose bit 3 is 0 is dropped. The byte after it is tried as status.
- R8: If no device clock falling edge arrives for `TIMEOUT_CYC` system cycles while a word or a packet is under way, the bit and byte positions go back to the start.
- R9: All report outputs keep their values between strobes, including across dropped bytes and timeouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Device clock line (asynchronous, idles high) |
| ps2_dat_i | input | 1 | Device data line (asynchronous, idles high) |
| rpt_vld | output | 1 | One-cycle strobe: a new report is on the outputs |
| btn_left | output | 1 | Left button pressed |
| btn_right | output | 1 | Right button pressed |
| move_x | output | 9 | Horizontal motion, two's complement, positive is right |
| move_y | output | 9 | Vertical motion, two's complement, positive is up |
| ovf_x | output | 1 | Horizontal motion overflowed |
| ovf_y | output | 1 | Vertical motion overflowed |

## Verification
The strobe and the new field values are due 4 system cycles after the bench pulls the device clock low for the final stop bit. Two of those cycles are the synchroniser, one is the edge detect plus the word register, and one is the report register. The bench records the cycle count at that falling edge and sets the due cycle 4 counts later. It compares `rpt_vld` against its expected-report queue on every falling system edge, so an early, late, missing or extra strobe is caught. The held values are checked at idle points long after the last strobe.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;
  localparam int DATA_BITS = 8;
  localparam int WORD_BITS = DATA_BITS + 3;
  localparam int MOVE_W    = DATA_BITS + 1;

  // position of each field inside the status byte
  localparam int ST_LEFT  = 0;
  localparam int ST_RIGHT = 1;
  localparam int ST_SYNC  = 3;
  localparam int ST_XSIGN = 4;
  localparam int ST_YSIGN = 5;
  localparam int ST_XOVF  = 6;
  localparam int ST_YOVF  = 7;

  typedef enum logic [1:0] {
    SLOT_STATUS = 2'd0,
    SLOT_XMOVE  = 2'd1,
    SLOT_YMOVE  = 2'd2
  } slot_e;
endpackage

// File: rtl/ps2m_sync.sv
module ps2m_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ck_in,
  input  logic dt_in,
  output logic ck_fall,
  output logic dt_q
);
  logic [STAGES-1:0] ck_pipe;
  logic [STAGES-1:0] dt_pipe;
  logic              ck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_pipe <= '1;
      dt_pipe <= '1;
      ck_last <= 1'b1;
    end else begin
      ck_pipe <= {ck_pipe[STAGES-2:0], ck_in};
      dt_pipe <= {dt_pipe[STAGES-2:0], dt_in};
      ck_last <= ck_pipe[STAGES-1];
    end
  end

  assign ck_fall = ck_last & ~ck_pipe[STAGES-1];
  assign dt_q    = dt_pipe[STAGES-1];
endmodule

// File: rtl/ps2m_word_rx.sv
module ps2m_word_rx
  import ps2m_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fall,
  input  logic                 din,
  input  logic                 hold,
  output logic                 byte_vld,
  output logic [DATA_BITS-1:0] byte_out,
  output logic                 frame_err,
  output logic                 tout
);
  localparam int CW  = $clog2(WORD_BITS);
  localparam int IW  = $clog2(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST_DATA = CW'(DATA_BITS);
  localparam logic [CW-1:0] PAR_POS   = CW'(DATA_BITS + 1);
  localparam logic [CW-1:0] STOP_POS  = CW'(WORD_BITS - 1);
  localparam logic [IW-1:0] IDLE_LIM  = IW'(TIMEOUT_CYC - 1);

  logic [CW-1:0]        bit_cnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_q;
  logic [IW-1:0]        idle_cnt;
  logic                 busy;

  assign busy     = (bit_cnt != '0) || hold;
  assign byte_out = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      par_q     <= 1'b0;
      idle_cnt  <= '0;
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      tout      <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      tout      <= 1'b0;
      if (fall) begin
        idle_cnt <= '0;
        if (bit_cnt == '0) begin
          if (!din) bit_cnt <= CW'(1);
          else      frame_err <= 1'b1;
        end else if (bit_cnt <= LAST_DATA) begin
          shreg   <= {din, shreg[DATA_BITS-1:1]};
          bit_cnt <= bit_cnt + CW'(1);
        end else if (bit_cnt == PAR_POS) begin
          par_q   <= din;
          bit_cnt <= STOP_POS;
        end else begin
          bit_cnt <= '0;
          if (din && (^{shreg, par_q})) byte_vld  <= 1'b1;
          else                          frame_err <= 1'b1;
        end
      end else if (busy) begin
        if (idle_cnt == IDLE_LIM) begin
          idle_cnt <= '0;
          bit_cnt  <= '0;
          tout     <= 1'b1;
        end else begin
          idle_cnt <= idle_cnt + IW'(1);
        end
      end else begin
        idle_cnt <= '0;
      end
    end
  end

  // R2: a word ends either accepted or rejected, never both
  p_accept_reject_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(byte_vld && frame_err));
  // R2: bit position never leaves the 11-bit word
  p_bitpos_range_r2: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= STOP_POS);
  // R8: a timeout leaves the word position at its start and yields no byte
  p_timeout_clears_r8: assert property (@(posedge clk) disable iff (rst)
    tout |-> (bit_cnt == '0) && !byte_vld);
endmodule

// File: rtl/ps2m_pkt_asm.sv
module ps2m_pkt_asm
  import ps2m_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 byte_vld,
  input  logic [DATA_BITS-1:0] byte_in,
  input  logic                 abort,
  output logic                 pkt_mid,
  output logic                 rpt_vld,
  output logic                 btn_left,
  output logic                 btn_right,
  output logic [MOVE_W-1:0]    move_x,
  output logic [MOVE_W-1:0]    move_y,
  output logic                 ovf_x,
  output logic                 ovf_y
);
  slot_e                slot;
  logic [DATA_BITS-1:0] stat_q;
  logic [DATA_BITS-1:0] xb_q;

  assign pkt_mid = (slot != SLOT_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= SLOT_STATUS;
      stat_q    <= '0;
      xb_q      <= '0;
      rpt_vld   <= 1'b0;
      btn_left  <= 1'b0;
      btn_right <= 1'b0;
      move_x    <= '0;
      move_y    <= '0;
      ovf_x     <= 1'b0;
      ovf_y     <= 1'b0;
    end else begin
      rpt_vld <= 1'b0;
      if (abort) begin
        slot <= SLOT_STATUS;
      end else if (byte_vld) begin
        unique case (slot)
          SLOT_STATUS: begin
            if (byte_in[ST_SYNC]) begin
              stat_q <= byte_in;
              slot   <= SLOT_XMOVE;
            end
          end
          SLOT_XMOVE: begin
            xb_q <= byte_in;
            slot <= SLOT_YMOVE;
          end
          default: begin
            rpt_vld   <= 1'b1;
            btn_left  <= stat_q[ST_LEFT];
            btn_right <= stat_q[ST_RIGHT];
            ovf_x     <= stat_q[ST_XOVF];
            ovf_y     <= stat_q[ST_YOVF];
            move_x    <= {stat_q[ST_XSIGN], xb_q};
            move_y    <= {stat_q[ST_YSIGN], byte_in};
            slot      <= SLOT_STATUS;
          end
        endcase
      end
    end
  end

  // R4: the strobe lasts a single cycle
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    rpt_vld |=> !rpt_vld);
  // R4: a report only follows an accepted byte
  p_strobe_after_byte_r4: assert property (@(posedge clk) disable iff (rst)
    rpt_vld |-> $past(byte_vld));
  // R5: the published flags match the stored status byte
  p_flags_from_status_r5: assert property (@(posedge clk) disable iff (rst)
    rpt_vld |-> (ovf_x == stat_q[ST_XOVF]) && (move_y[MOVE_W-1] == stat_q[ST_YSIGN]));
  // R7: a status candidate without the sync bit keeps the slot at status
  p_resync_r7: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !abort && slot == SLOT_STATUS && !byte_in[ST_SYNC]) |=> slot == SLOT_STATUS);
  // R9: outputs only move with a strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rpt_vld |-> $stable(move_x) && $stable(move_y) && $stable(btn_left));
endmodule

// File: rtl/ps2_mouse_rx.sv
module ps2_mouse_rx
  import ps2m_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              rpt_vld,
  output logic              btn_left,
  output logic              btn_right,
  output logic [MOVE_W-1:0] move_x,
  output logic [MOVE_W-1:0] move_y,
  output logic              ovf_x,
  output logic              ovf_y
);
  logic                 fall;
  logic                 dsync;
  logic                 pkt_mid;
  logic                 byte_vld;
  logic [DATA_BITS-1:0] byte_val;
  logic                 frame_err;
  logic                 tout;

  ps2m_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ck_in(ps2_clk_i), .dt_in(ps2_dat_i),
    .ck_fall(fall), .dt_q(dsync)
  );

  ps2m_word_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_word (
    .clk(clk), .rst(rst), .fall(fall), .din(dsync), .hold(pkt_mid),
    .byte_vld(byte_vld), .byte_out(byte_val), .frame_err(frame_err), .tout(tout)
  );

  ps2m_pkt_asm u_asm (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_val),
    .abort(frame_err | tout), .pkt_mid(pkt_mid),
    .rpt_vld(rpt_vld), .btn_left(btn_left), .btn_right(btn_right),
    .move_x(move_x), .move_y(move_y), .ovf_x(ovf_x), .ovf_y(ovf_y)
  );
endmodule

// File: tb/ps2_mouse_rx_tb.sv
module ps2_mouse_rx_tb;
  localparam int TO   = 1000;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pclk = 1'b1;
  logic pdat = 1'b1;
  logic rpt_vld, btn_left, btn_right, ovf_x, ovf_y;
  logic [8:0] move_x, move_y;

  always #2 clk = ~clk;

  ps2_mouse_rx #(.TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst(rst), .ps2_clk_i(pclk), .ps2_dat_i(pdat),
    .rpt_vld(rpt_vld), .btn_left(btn_left), .btn_right(btn_right),
    .move_x(move_x), .move_y(move_y), .ovf_x(ovf_x), .ovf_y(ovf_y)
  );

  typedef struct {
    int         due;
    logic       l, r, ox, oy;
    logic [8:0] x, y;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t pend;
  bit   pend_en = 0;
  exp_t last;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() != 0 && cyc == q[0].due) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "rpt_vld (R3 R4)", int'(rpt_vld), 1);
        chk(e.tag, "btn_left (R5)", int'(btn_left), int'(e.l));
        chk(e.tag, "btn_right (R5)", int'(btn_right), int'(e.r));
        chk(e.tag, "move_x (R5)", int'(move_x), int'(e.x));
        chk(e.tag, "move_y (R5)", int'(move_y), int'(e.y));
        chk(e.tag, "ovf_x (R5)", int'(ovf_x), int'(e.ox));
        chk(e.tag, "ovf_y (R5)", int'(ovf_y), int'(e.oy));
        last = e;
      end else if (rpt_vld) begin
        chk("R4 R6 R7", "unexpected report strobe", 1, 0);
      end
    end
  end

  task automatic ps2_bit(input logic b, input bit is_stop);
    @(posedge clk); #1 pdat = b;
    repeat (HALF) @(posedge clk);
    #1 pclk = 1'b0;
    if (is_stop && pend_en) begin
      pend.due = cyc + 4;
      q.push_back(pend);
      pend_en = 0;
    end
    repeat (HALF) @(posedge clk);
    #1 pclk = 1'b1;
  endtask

  task automatic send_word(input logic [7:0] v, input bit bad_par, input bit bad_stop);
    ps2_bit(1'b0, 0);
    for (int i = 0; i < 8; i++) ps2_bit(v[i], 0);
    ps2_bit((~^v) ^ bad_par, 0);
    ps2_bit(~bad_stop, 1);
    #1 pdat = 1'b1;
    repeat (3 * HALF) @(posedge clk);
  endtask

  function automatic logic [7:0] stat_of(input logic l, input logic r,
                                         input logic [8:0] x, input logic [8:0] y,
                                         input logic ox, input logic oy);
    return {oy, ox, y[8], x[8], 1'b1, 1'b0, r, l};
  endfunction

  task automatic send_pkt(input logic l, input logic r, input logic [8:0] x,
                          input logic [8:0] y, input logic ox, input logic oy,
                          input string tag);
    send_word(stat_of(l, r, x, y, ox, oy), 0, 0);
    send_word(x[7:0], 0, 0);
    pend.l = l; pend.r = r; pend.x = x; pend.y = y;
    pend.ox = ox; pend.oy = oy; pend.tag = tag; pend_en = 1;
    send_word(y[7:0], 0, 0);
    repeat (10) @(posedge clk);
  endtask

  task automatic hold_check(input string tag);
    @(negedge clk);
    chk(tag, "held move_x (R9)", int'(move_x), int'(last.x));
    chk(tag, "held move_y (R9)", int'(move_y), int'(last.y));
    chk(tag, "held buttons (R9)", int'({btn_left, btn_right}), int'({last.l, last.r}));
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    chk("R1", "rpt_vld", int'(rpt_vld), 0);
    chk("R1", "buttons", int'({btn_left, btn_right}), 0);
    chk("R1", "move", int'({move_x, move_y}), 0);
    chk("R1", "ovf", int'({ovf_x, ovf_y}), 0);
    repeat (20) @(posedge clk);

    send_pkt(1, 0, 9'd5, 9'd3, 0, 0, "R4 basic");
    send_pkt(0, 1, 9'h1EC, 9'h1FF, 0, 0, "R5 negative");
    send_pkt(1, 1, 9'h0FF, 9'h080, 1, 1, "R5 overflow");

    // R6: bad parity on the horizontal byte
    send_word(stat_of(0, 0, 9'd1, 9'd1, 0, 0), 0, 0);
    send_word(8'h11, 1, 0);
    hold_check("R6 parity");
    send_pkt(0, 0, 9'd7, 9'd9, 0, 0, "R6 after parity");

    // R2: bad stop bit
    send_word(stat_of(0, 0, 9'd1, 9'd1, 0, 0), 0, 0);
    send_word(8'h22, 0, 1);
    hold_check("R2 stop");
    send_pkt(1, 0, 9'h100, 9'd0, 0, 0, "R2 after stop");

    // R6: bad start bit
    send_word(stat_of(0, 0, 9'd1, 9'd1, 0, 0), 0, 0);
    ps2_bit(1'b1, 0);
    repeat (3 * HALF) @(posedge clk);
    send_pkt(0, 1, 9'd2, 9'h1FE, 0, 0, "R6 after start");

    // R7: status candidate lacking bit 3
    send_word(8'h00, 0, 0);
    hold_check("R7 dropped");
    send_pkt(1, 1, 9'd40, 9'd50, 0, 0, "R7 resync");

    // R8: stall inside a word
    for (int i = 0; i < 5; i++) ps2_bit(1'b0, 0);
    repeat (TO + 200) @(posedge clk);
    send_pkt(0, 0, 9'd11, 9'd12, 0, 1, "R8 word stall");

    // R8: stall inside a packet
    send_word(stat_of(1, 0, 9'd3, 9'd3, 0, 0), 0, 0);
    send_word(8'h33, 0, 0);
    repeat (TO + 200) @(posedge clk);
    hold_check("R8 packet stall");
    send_pkt(1, 0, 9'h1F0, 9'd6, 1, 0, "R8 packet stall");

    repeat (200) @(posedge clk);
    hold_check("R9 final");
    chk("R3 R4", "queue drained", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule